// File: doc/BRIEF.md
# Pause Frame Generator

This block is the transmit-side flow-control engine of an Ethernet MAC. It builds IEEE 802.3x PAUSE control frames and streams them one byte per cycle to the transmit path, which appends the FCS. A frame can come from two sources. A host writes a 16-bit quanta value and pulses a start strobe. A FIFO congestion signal also queues frames on its own: its rising edge queues a frame carrying the programmed quanta. Its falling edge queues a zero-quanta frame, which releases the link partner, unless a disable input is set.

The host-facing `busy` flag stays high from an accepted start until the last byte of that host frame has been taken by the transmit path. A start strobe seen while `busy` is high is ignored. The output stream is valid/ready. `tx_valid` never drops and `tx_data` never changes while the sink holds `tx_ready` low. A byte transfers on every cycle where both are high. The sink may stall for any number of cycles. A host request and an automatic request that are pending together are sent back to back, host first, and both are sent.

Top module: `pause_frame_gen`

## Requirements
- R1: While reset is applied and on the first cycle after it, `busy` and `tx_valid` are 0.
- R2: A `host_start` pulse with `busy` at 0 raises `busy` on the next cycle. `busy` stays 1 until the cycle after the handshake of the last byte of that host frame.
- R3: Every frame is 60 bytes, sent in this order: destination 01 80 C2 00 00 01; `station_addr` bits 47:40 first down to bits 7:0; type 88 08; opcode 00 01; quanta high byte, then low byte; zero bytes up to byte 59.
- R4: A host frame carries the `host_pause_time` value that was present on its accepted start.
- R5: A rising edge of `fifo_congest` queues a frame carrying the quanta register as it stood before that cycle's host write.
- R6: A falling edge of `fifo_congest` with `zq_disable` at 0 queues a frame with quanta 0.
- R7: A falling edge of `fifo_congest` with `zq_disable` at 1 queues no frame.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, the next cycle keeps `tx_valid` at 1 and `tx_data` unchanged. `tx_last` is 1 only on byte 59.
- R9: When a host request and an automatic request are both pending, the host frame is sent first and the automatic frame follows. Neither is lost.
- R10: A `host_start` pulse while `busy` is 1 has no effect. It changes neither the quanta nor the number of frames.
- R11: An automatic request that has not yet begun transmission is replaced by a later congestion edge. Only the latest one is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_start | input | 1 | Host request strobe for one frame |
| host_pause_time | input | 16 | Quanta captured on an accepted start |
| station_addr | input | 48 | Source MAC address |
| zq_disable | input | 1 | Suppresses the zero-quanta frame on congestion release |
| fifo_congest | input | 1 | FIFO-layer congestion indication |
| busy | output | 1 | Host frame pending or in flight |
| tx_valid | output | 1 | Byte valid toward the transmit path |
| tx_ready | input | 1 | Transmit path accepts the byte |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Marks the final pad byte |

## Verification
The hardest case to reach is a pending automatic request that gets replaced while a host frame occupies the output. It also has to line up with a host start on the same cycle as a congestion edge. The stimulus first starts a host frame. Once that frame is streaming, it toggles `fifo_congest` up and then down, so the queued request is overwritten before it can start. A separate run pulses `host_start` on the same cycle as a rising congestion edge, with the sink stalling on a fixed pattern. A behavioural byte-queue model checks the order and content of each frame.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam int PFG_QW = 16;
  localparam int PFG_HDR_BYTES = 18;
  localparam logic [47:0] PFG_DEST_MAC = 48'h0180C2000001;
  localparam logic [15:0] PFG_ETHERTYPE = 16'h8808;
  localparam logic [15:0] PFG_OPCODE = 16'h0001;

  typedef struct packed {
    logic              is_host;
    logic [PFG_QW-1:0] quanta;
  } pfg_req_t;
endpackage

// File: rtl/pfg_req_arbiter.sv
module pfg_req_arbiter
  import pfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_start,
  input  logic [PFG_QW-1:0] host_pt,
  input  logic              fifo_congest,
  input  logic              zq_disable,
  input  logic              grant,
  input  logic              host_active,
  output logic              req_valid,
  output pfg_req_t          req,
  output logic              busy
);
  logic              host_pend, auto_pend, cong_q;
  logic [PFG_QW-1:0] pt_reg, auto_pt;
  logic              accept, rise, fall;

  assign busy      = host_pend | host_active;
  assign accept    = host_start & ~busy;
  assign rise      = fifo_congest & ~cong_q;
  assign fall      = ~fifo_congest & cong_q;
  assign req_valid = host_pend | auto_pend;
  assign req.is_host = host_pend;
  assign req.quanta  = host_pend ? pt_reg : auto_pt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_pend <= 1'b0;
      pt_reg    <= '0;
    end else if (accept) begin
      host_pend <= 1'b1;
      pt_reg    <= host_pt;
    end else if (grant && host_pend) begin
      host_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_pend <= 1'b0;
      auto_pt   <= '0;
      cong_q    <= 1'b0;
    end else begin
      cong_q <= fifo_congest;
      if (rise) begin
        auto_pend <= 1'b1;
        auto_pt   <= pt_reg;
      end else if (fall && !zq_disable) begin
        auto_pend <= 1'b1;
        auto_pt   <= '0;
      end else if (grant && !host_pend) begin
        auto_pend <= 1'b0;
      end
    end
  end

  // R2: an accepted start makes the block busy
  p_start_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_start && !busy |=> busy);
  // R10: a start while busy leaves the quanta register alone
  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_start && busy |=> $stable(pt_reg));
  // R5: a congestion rise leaves an automatic request queued
  p_rise_queues_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_congest && !cong_q |=> auto_pend);
endmodule

// File: rtl/pfg_streamer.sv
module pfg_streamer
  import pfg_pkg::*;
#(
  parameter int FRAME_BYTES = 60,
  localparam int IDX_W = $clog2(FRAME_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  pfg_req_t         req,
  input  logic             tx_ready,
  output logic             grant,
  output pfg_req_t         cur,
  output logic [IDX_W-1:0] idx,
  output logic             tx_valid,
  output logic             tx_last,
  output logic             host_active
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

  logic active;

  assign grant       = ~active & req_valid;
  assign tx_valid    = active;
  assign tx_last     = active && (idx == LAST_IDX);
  assign host_active = active & cur.is_host;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      cur    <= '0;
    end else if (grant) begin
      active <= 1'b1;
      idx    <= '0;
      cur    <= req;
    end else if (active && tx_ready) begin
      if (idx == LAST_IDX) active <= 1'b0;
      else                 idx    <= idx + 1'b1;
    end
  end

  // R8: a stalled byte stays offered at the same position
  p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active && !tx_ready |=> active && $stable(idx) && $stable(cur));
  // R8: the final byte, once taken, ends the frame
  p_last_ends_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last && tx_ready |=> !tx_last);
endmodule

// File: rtl/pfg_byte_mux.sv
module pfg_byte_mux
  import pfg_pkg::*;
#(
  parameter int FRAME_BYTES = 60,
  localparam int IDX_W = $clog2(FRAME_BYTES)
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [47:0]       station_addr,
  input  logic [PFG_QW-1:0] quanta,
  output logic [7:0]        byte_out
);
  localparam int HDR_W = 8 * PFG_HDR_BYTES;

  logic [HDR_W-1:0] hdr;
  logic [7:0]       hdr_b [PFG_HDR_BYTES];

  assign hdr = {PFG_DEST_MAC, station_addr, PFG_ETHERTYPE, PFG_OPCODE, quanta};

  for (genvar g = 0; g < PFG_HDR_BYTES; g++) begin : g_split
    assign hdr_b[g] = hdr[8*(PFG_HDR_BYTES-1-g) +: 8];
  end

  always_comb begin
    byte_out = 8'h00;
    for (int i = 0; i < PFG_HDR_BYTES; i++) begin
      if (idx == IDX_W'(i)) byte_out = hdr_b[i];
    end
  end
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
  import pfg_pkg::*;
#(
  parameter int FRAME_BYTES = 60,
  localparam int IDX_W = $clog2(FRAME_BYTES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_start,
  input  logic [15:0] host_pause_time,
  input  logic [47:0] station_addr,
  input  logic        zq_disable,
  input  logic        fifo_congest,
  output logic        busy,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  output logic        tx_last
);
  logic             req_valid, grant, host_active;
  pfg_req_t         req, cur;
  logic [IDX_W-1:0] idx;

  pfg_req_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_pt(host_pause_time),
    .fifo_congest(fifo_congest), .zq_disable(zq_disable), .grant(grant),
    .host_active(host_active), .req_valid(req_valid), .req(req), .busy(busy)
  );

  pfg_streamer #(.FRAME_BYTES(FRAME_BYTES)) u_str (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req(req), .tx_ready(tx_ready),
    .grant(grant), .cur(cur), .idx(idx), .tx_valid(tx_valid), .tx_last(tx_last),
    .host_active(host_active)
  );

  pfg_byte_mux #(.FRAME_BYTES(FRAME_BYTES)) u_mux (
    .idx(idx), .station_addr(station_addr), .quanta(cur.quanta), .byte_out(tx_data)
  );

  // R2: busy drops only right after the last byte of a frame is taken
  p_busy_falls_on_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tx_valid && tx_ready && tx_last));
  // R8: output byte is frozen while the sink stalls
  p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
endmodule

// File: tb/pause_frame_gen_test.sv
module pause_frame_gen_test;
  logic        clk = 0, rst_n = 0;
  logic        host_start = 0, zq_disable = 0, fifo_congest = 0, tx_ready = 1;
  logic [15:0] host_pause_time = 0;
  logic [47:0] station_addr = 48'hA1B2C3D4E5F6;
  logic        busy, tx_valid, tx_last;
  logic [7:0]  tx_data;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pause_frame_gen uut (
    .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_pause_time(host_pause_time),
    .station_addr(station_addr), .zq_disable(zq_disable), .fifo_congest(fifo_congest),
    .busy(busy), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last)
  );

  // behavioural model
  bit         m_hp, m_ap, m_act, m_host, m_cq;
  int         m_pt, m_apt;
  logic [7:0] mq[$];
  logic [7:0] rx[$];
  int         obs[$];

  function automatic void build(ref logic [7:0] q[$], input int pt);
    q.delete();
    q.push_back(8'h01); q.push_back(8'h80); q.push_back(8'hC2);
    q.push_back(8'h00); q.push_back(8'h00); q.push_back(8'h01);
    for (int i = 5; i >= 0; i--) q.push_back(station_addr[8*i +: 8]);
    q.push_back(8'h88); q.push_back(8'h08); q.push_back(8'h00); q.push_back(8'h01);
    q.push_back(8'((pt >> 8) & 255)); q.push_back(8'(pt & 255));
    while (q.size() < 60) q.push_back(8'h00);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hp = 0; m_ap = 0; m_act = 0; m_host = 0; m_cq = 0; m_pt = 0; m_apt = 0; mq.delete();
    end else begin
      bit bsy;
      int old_pt;
      bsy = m_hp || (m_act && m_host);
      old_pt = m_pt;
      if (!m_act && (m_hp || m_ap)) begin
        build(mq, m_hp ? m_pt : m_apt);
        m_host = m_hp;
        if (m_hp) m_hp = 0; else m_ap = 0;
        m_act = 1;
      end else if (m_act && tx_ready) begin
        void'(mq.pop_front());
        if (mq.size() == 0) m_act = 0;
      end
      if (host_start && !bsy) begin m_hp = 1; m_pt = int'(host_pause_time); end
      if (fifo_congest && !m_cq) begin m_ap = 1; m_apt = old_pt; end
      else if (!fifo_congest && m_cq && !zq_disable) begin m_ap = 1; m_apt = 0; end
      m_cq = fifo_congest;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // capture a handshake that will happen on the coming edge
  task automatic capture();
    if (tx_valid && tx_ready) begin
      rx.push_back(tx_data);
      if (tx_last) begin
        logic [7:0] ref_q[$];
        int pt;
        bit same;
        chk(rx.size() == 60, "R8 frame length", rx.size(), 60);
        pt = (rx.size() >= 18) ? {rx[16], rx[17]} : 0;
        build(ref_q, pt);
        same = (rx.size() == 60);
        for (int i = 0; i < 60 && same; i++) if (rx[i] !== ref_q[i]) same = 0;
        chk(same, "R3 frame layout", pt, pt);
        obs.push_back(pt);
        rx.delete();
      end
    end
  endtask

  task automatic tick(int n = 1);
    for (int k = 0; k < n; k++) begin
      capture();
      @(negedge clk);
      if (busy !== (m_hp || (m_act && m_host))) begin
        tests++; fails++;
        $display("FAIL R2 busy: actual %0b expected %0b at %0t", busy, m_hp || (m_act && m_host), $time);
      end
      if (tx_valid !== m_act) begin
        tests++; fails++;
        $display("FAIL R8 valid: actual %0b expected %0b at %0t", tx_valid, m_act, $time);
      end else if (m_act) begin
        if (tx_data !== mq[0] || tx_last !== (mq.size() == 1)) begin
          tests++; fails++;
          $display("FAIL R3 byte/last: actual %0h/%0b expected %0h/%0b at %0t",
                   tx_data, tx_last, mq[0], mq.size() == 1, $time);
        end
      end
    end
  endtask

  task automatic pulse_host(int pt);
    host_start = 1; host_pause_time = 16'(pt);
    tick();
    host_start = 0;
  endtask

  task automatic check_obs(string req, int exp[$]);
    chk(obs.size() == exp.size(), {req, " frame count"}, obs.size(), exp.size());
    for (int i = 0; i < exp.size() && i < obs.size(); i++)
      chk(obs[i] == exp[i], {req, " quanta"}, obs[i], exp[i]);
    obs.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 0 && tx_valid === 0, "R1 reset outputs", {busy, tx_valid}, 0);
    rst_n = 1;
    tick();
    chk(busy === 0 && tx_valid === 0, "R1 after reset", {busy, tx_valid}, 0);

    // R2 R4: plain host frame
    pulse_host(16'h1234);
    chk(busy === 1, "R2 busy after start", busy, 1);
    tick(100);
    check_obs("R4", '{16'h1234});

    // R8 R10: stalled sink, start ignored while busy
    pulse_host(16'hBEEF);
    for (int c = 0; c < 200; c++) begin
      tx_ready = (c % 3) != 0;
      if (c == 10) host_start = 1; else host_start = 0;
      host_pause_time = (c == 10) ? 16'h5555 : 16'hBEEF;
      tick();
    end
    host_start = 0; tx_ready = 1;
    tick(10);
    check_obs("R10", '{16'hBEEF});

    // R5 R6: congestion on, then release with zero quanta
    fifo_congest = 1; tick(100);
    fifo_congest = 0; tick(100);
    check_obs("R5 R6", '{16'hBEEF, 0});

    // R7: release suppressed
    zq_disable = 1;
    fifo_congest = 1; tick(100);
    fifo_congest = 0; tick(100);
    check_obs("R7", '{16'hBEEF});
    zq_disable = 0;

    // R9: host start on the same cycle as a congestion rise, stalling sink
    host_start = 1; host_pause_time = 16'h0A0B; fifo_congest = 1;
    tick();
    host_start = 0;
    for (int c = 0; c < 250; c++) begin tx_ready = (c % 4) != 1; tick(); end
    tx_ready = 1;
    check_obs("R9", '{16'h0A0B, 16'hBEEF});
    fifo_congest = 0; tick(100);
    check_obs("R6", '{0});

    // R11: pending automatic request replaced during a host frame
    pulse_host(16'h7777);
    tick(5);
    fifo_congest = 1; tick(2);
    fifo_congest = 0; tick(200);
    check_obs("R11", '{16'h7777, 0});
    chk(busy === 0 && tx_valid === 0, "R2 idle at end", {busy, tx_valid}, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule